// File: doc/BRIEF.md
# GPIO Interrupt Detect and Mask Unit

This block watches a bank of general purpose input pins and turns programmed pin activity into one interrupt line. Each pin has its own trigger choice: rising edge, falling edge, both edges, high level or low level. A detected trigger is recorded in a per-pin pending bit. A per-pin mask decides whether that pending bit reaches the shared interrupt output. Software can then find the source by reading the pending bits and the mask.

The pins are asynchronous to the block clock. They pass through a synchronizer before any detection logic sees them. A small word-addressed register port with a write strobe gives access to the configuration. Reads are combinational on the address. The mask cannot be written directly. Software changes it through two write-one registers, one that unmasks bits and one that masks them, so that updating one pin never needs a read-modify-write of the others.

Top module: `gpio_irq_unit`

## Requirements
- R1: While reset is asserted, and on leaving reset, every mask bit reads 1 (masked). Pending, trigger-kind, polarity and both-edge bits read 0, and `irq` is 0.
- R2: The register word addresses are: 0 mask (read-only), 1 unmask, 2 mask-set, 3 pending, 4 trigger kind, 5 polarity, 6 both-edge. Addresses 1, 2 and 7 read as 0. The trigger-kind, polarity and both-edge registers read back the value last written.
- R3: Writing to address 1 clears the mask bit of every pin whose data bit is 1. Data bits that are 0 leave their mask bits unchanged.
- R4: Writing to address 2 sets the mask bit of every pin whose data bit is 1. Data bits that are 0 leave their mask bits unchanged.
- R5: A pin with trigger kind 1, polarity 1 and both-edge 0 sets its pending bit on a 0-to-1 input transition only.
- R6: A pin with trigger kind 1, polarity 0 and both-edge 0 sets its pending bit on a 1-to-0 input transition only.
- R7: A pin with trigger kind 1 and both-edge 1 sets its pending bit on either transition, whatever its polarity.
- R8: A pin with trigger kind 0 is level sensitive, and its both-edge bit has no effect. Its pending bit is 1 while the input is at the active level (high when polarity is 1, low when polarity is 0) and 0 otherwise. A write-one to the pending register does not clear it while the input stays active.
- R9: The pending bit of an edge-sensitive pin stays set until a 1 is written to that bit at address 3. Writing 0 to it has no effect.
- R10: If a new edge is detected on a pin in the same cycle as a write-one clear of that pin's pending bit, the pending bit remains 1.
- R11: `irq` is 1 exactly when some pin has its pending bit 1 and its mask bit 0. A masked pin's pending bit is still set and held.
- R12: An input change reaches the pending bit at the third rising clock edge after it is applied: two synchronizer stages plus the pending register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | NBITS | Register write data |
| rdata | output | NBITS | Register read data for `addr` |
| gpio_in | input | NBITS | Asynchronous input pins |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the unit with `NBITS` set to 8 and keeps the default synchronizer depth of two. With eight pins, the full bank fits in a byte, so the mask, trigger and pending patterns can be written out as whole-bank values. This makes it practical to mix modes across pins and to confirm that writing zero bits leaves untouched pins alone. The default depth lets the bench pin the three-edge input latency, and hit the exact cycle where a new edge meets a clear write.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_MASK     = 3'd0,
    RA_UNMASK   = 3'd1,
    RA_SETMASK  = 3'd2,
    RA_PEND     = 3'd3,
    RA_KIND     = 3'd4,
    RA_POL      = 3'd5,
    RA_BOTH     = 3'd6
  } reg_addr_e;

endpackage

// File: rtl/gpio_irq_rst_sync.sv
module gpio_irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stage_d[s] = din;
    end else begin : g_next
      assign stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d[s];
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      mask,
  output logic [W-1:0]      kind,
  output logic [W-1:0]      pol,
  output logic [W-1:0]      both,
  output logic [W-1:0]      pend_clr
);

  logic [W-1:0] mask_q, mask_d;
  logic [W-1:0] kind_q, kind_d;
  logic [W-1:0] pol_q,  pol_d;
  logic [W-1:0] both_q, both_d;
  logic         mask_en, kind_en, pol_en, both_en;

  always_comb begin
    mask_en  = wr_en && ((addr == RA_UNMASK) || (addr == RA_SETMASK));
    kind_en  = wr_en && (addr == RA_KIND);
    pol_en   = wr_en && (addr == RA_POL);
    both_en  = wr_en && (addr == RA_BOTH);

    mask_d = mask_q;
    if (addr == RA_UNMASK)       mask_d = mask_q & ~wdata;
    else if (addr == RA_SETMASK) mask_d = mask_q | wdata;

    kind_d = wdata;
    pol_d  = wdata;
    both_d = wdata;

    pend_clr = (wr_en && (addr == RA_PEND)) ? wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      kind_q <= '0;
      pol_q  <= '0;
      both_q <= '0;
    end else begin
      if (mask_en) mask_q <= mask_d;
      if (kind_en) kind_q <= kind_d;
      if (pol_en)  pol_q  <= pol_d;
      if (both_en) both_q <= both_d;
    end
  end

  assign mask = mask_q;
  assign kind = kind_q;
  assign pol  = pol_q;
  assign both = both_q;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_s,
  input  logic [W-1:0] kind,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] both,
  input  logic [W-1:0] pend_clr,
  output logic [W-1:0] pend
);

  logic [W-1:0] prev_q;
  logic [W-1:0] pend_q, pend_d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic rise, fall, hit, active;
    assign rise   = pin_s[i] & ~prev_q[i];
    assign fall   = ~pin_s[i] & prev_q[i];
    assign hit    = both[i] ? (rise | fall) : (pol[i] ? rise : fall);
    assign active = pol[i] ? pin_s[i] : ~pin_s[i];
    assign pend_d[i] = kind[i] ? (hit | (pend_q[i] & ~pend_clr[i])) : active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= pin_s;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int NBITS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [NBITS-1:0]  wdata,
  output logic [NBITS-1:0]  rdata,
  input  logic [NBITS-1:0]  gpio_in,
  output logic              irq
);

  logic             rst_sync_n;
  logic [NBITS-1:0] pin_s;
  logic [NBITS-1:0] mask, kind, pol, both, pend_clr, pend;

  gpio_irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_irq_sync #(.W(NBITS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   (gpio_in),
    .dout  (pin_s)
  );

  gpio_irq_cfg #(.W(NBITS)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .mask     (mask),
    .kind     (kind),
    .pol      (pol),
    .both     (both),
    .pend_clr (pend_clr)
  );

  gpio_irq_detect #(.W(NBITS)) u_det (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pin_s    (pin_s),
    .kind     (kind),
    .pol      (pol),
    .both     (both),
    .pend_clr (pend_clr),
    .pend     (pend)
  );

  always_comb begin
    case (addr)
      RA_MASK: rdata = mask;
      RA_PEND: rdata = pend;
      RA_KIND: rdata = kind;
      RA_POL:  rdata = pol;
      RA_BOTH: rdata = both;
      default: rdata = '0;
    endcase
  end

  assign irq = |(pend & ~mask);

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [REG_AW-1:0] addr,
  input logic [W-1:0]      wdata,
  input logic [W-1:0]      mask,
  input logic [W-1:0]      kind,
  input logic [W-1:0]      pend,
  input logic              irq
);

  // R3: unmask write clears the selected mask bits
  a_r3_unmask_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == RA_UNMASK) |=> ((mask & $past(wdata)) == '0));

  // R4: mask-set write sets the selected mask bits
  a_r4_setmask_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == RA_SETMASK) |=> ((mask & $past(wdata)) == $past(wdata)));

  // R9: edge-held pending bits never drop without a clear or kind change
  a_r9_edge_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && addr == RA_PEND) && !(wr_en && addr == RA_KIND))
      |=> (($past(pend & kind) & ~pend) == '0));

  // R11: a fully masked bank never raises the interrupt
  a_r11_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq);

  // R11: no pending bit means no interrupt
  a_r11_no_pend_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> !irq);

endmodule

bind gpio_irq_unit gpio_irq_chk #(.W(NBITS)) u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .wr_en (wr_en),
  .addr  (addr),
  .wdata (wdata),
  .mask  (mask),
  .kind  (kind),
  .pend  (pend),
  .irq   (irq)
);

// File: tb/gpio_irq_unit_bench.sv
`timescale 1ns/1ps
module gpio_irq_unit_bench;

  localparam int N = 8;
  localparam logic [2:0] A_MASK = 3'd0, A_UNM = 3'd1, A_SETM = 3'd2,
                         A_PEND = 3'd3, A_KIND = 3'd4, A_POL = 3'd5,
                         A_BOTH = 3'd6, A_NONE = 3'd7;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [2:0]   addr;
  logic [N-1:0] wdata;
  logic [N-1:0] rdata;
  logic [N-1:0] gin;
  logic         irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gpio_irq_unit #(.NBITS(N)) u_gpio_irq_unit (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .gpio_in (gin),
    .irq     (irq)
  );

  task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pins(input logic [N-1:0] v);
    gin = v;
    idle(3);
  endtask

  task automatic expect_reg(input string req, input logic [2:0] a, input logic [N-1:0] exp);
    logic [N-1:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic t_reset;
    expect_reg("R1 mask", A_MASK, 8'hFF);
    expect_reg("R1 pend", A_PEND, 8'h00);
    expect_reg("R1 kind", A_KIND, 8'h00);
    expect_reg("R1 pol",  A_POL,  8'h00);
    expect_reg("R1 both", A_BOTH, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    expect_reg("R2 unmask reads 0", A_UNM, 8'h00);
    expect_reg("R2 setmask reads 0", A_SETM, 8'h00);
    expect_reg("R2 addr7 reads 0", A_NONE, 8'h00);
  endtask

  task automatic t_mask;
    wr(A_UNM, 8'h0F);  expect_reg("R3 unmask low nibble", A_MASK, 8'hF0);
    wr(A_UNM, 8'h00);  expect_reg("R3 zero write no change", A_MASK, 8'hF0);
    wr(A_SETM, 8'h03); expect_reg("R4 setmask two bits", A_MASK, 8'hF3);
    wr(A_SETM, 8'h00); expect_reg("R4 zero write no change", A_MASK, 8'hF3);
    wr(A_UNM, 8'hFF);  expect_reg("R3 unmask all", A_MASK, 8'h00);
    wr(A_SETM, 8'hFF); expect_reg("R4 mask all", A_MASK, 8'hFF);
  endtask

  task automatic t_readback;
    wr(A_KIND, 8'hA5); expect_reg("R2 kind readback", A_KIND, 8'hA5);
    wr(A_POL,  8'h3C); expect_reg("R2 pol readback",  A_POL,  8'h3C);
    wr(A_BOTH, 8'h81); expect_reg("R2 both readback", A_BOTH, 8'h81);
    wr(A_KIND, 8'hFF); wr(A_POL, 8'hFF); wr(A_BOTH, 8'h00);
    pins(8'h00);
    wr(A_PEND, 8'hFF);
    idle(2);
    expect_reg("R5 quiet after clear", A_PEND, 8'h00);
  endtask

  task automatic t_rising;
    logic [N-1:0] v;
    pins(8'h01);
    expect_reg("R5 rise sets", A_PEND, 8'h01);
    wr(A_PEND, 8'h01);
    pins(8'h00);
    expect_reg("R5 fall ignored", A_PEND, 8'h00);
    gin = 8'h02;
    idle(2);
    rd(A_PEND, v); check("R12 not yet after two edges", v, 8'h00);
    idle(1);
    rd(A_PEND, v); check("R12 set at third edge", v, 8'h02);
    wr(A_PEND, 8'hFF);
  endtask

  task automatic t_falling;
    wr(A_POL, 8'h00);
    pins(8'h00);
    expect_reg("R6 fall sets", A_PEND, 8'h02);
    pins(8'h01);
    expect_reg("R6 rise ignored", A_PEND, 8'h02);
    wr(A_PEND, 8'hFF);
    expect_reg("R9 clear all", A_PEND, 8'h00);
  endtask

  task automatic t_both;
    wr(A_BOTH, 8'hFF);
    pins(8'h00);
    expect_reg("R7 fall with both", A_PEND, 8'h01);
    wr(A_PEND, 8'hFF);
    pins(8'h01);
    expect_reg("R7 rise with both, pol 0", A_PEND, 8'h01);
    wr(A_PEND, 8'hFF);
  endtask

  task automatic t_level;
    wr(A_POL, 8'hFF);
    wr(A_KIND, 8'h00);
    idle(2);
    expect_reg("R8 high level, both ignored", A_PEND, 8'h01);
    wr(A_PEND, 8'h01);
    expect_reg("R8 clear ignored while active", A_PEND, 8'h01);
    pins(8'h00);
    expect_reg("R8 follows level down", A_PEND, 8'h00);
    wr(A_POL, 8'h00);
    idle(2);
    expect_reg("R8 low level active", A_PEND, 8'hFF);
    pins(8'hFF);
    expect_reg("R8 low level released", A_PEND, 8'h00);
  endtask

  task automatic t_w1c;
    wr(A_BOTH, 8'h00); wr(A_POL, 8'hFF); wr(A_KIND, 8'hFF);
    pins(8'h00);
    wr(A_PEND, 8'hFF);
    pins(8'h81);
    expect_reg("R9 two edges latched", A_PEND, 8'h81);
    wr(A_PEND, 8'h00);
    expect_reg("R9 zero write ignored", A_PEND, 8'h81);
    wr(A_PEND, 8'h01);
    expect_reg("R9 clear one bit", A_PEND, 8'h80);
    wr(A_PEND, 8'h80);
    expect_reg("R9 clear other bit", A_PEND, 8'h00);
  endtask

  task automatic t_collide;
    wr(A_BOTH, 8'hFF);
    pins(8'h80);
    expect_reg("R7 setup fall", A_PEND, 8'h01);
    gin = 8'h81;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = A_PEND; wdata = 8'h01;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    expect_reg("R10 edge beats clear", A_PEND, 8'h01);
    wr(A_PEND, 8'h01);
    expect_reg("R10 plain clear", A_PEND, 8'h00);
  endtask

  task automatic t_irq;
    pins(8'h80);
    idle(4);
    expect_reg("R11 held while masked", A_PEND, 8'h01);
    check("R11 masked no irq", {7'd0, irq}, 8'h00);
    wr(A_UNM, 8'h02);
    check("R11 other bit unmasked", {7'd0, irq}, 8'h00);
    wr(A_UNM, 8'h01);
    check("R11 unmask raises irq", {7'd0, irq}, 8'h01);
    wr(A_SETM, 8'h01);
    check("R11 remask drops irq", {7'd0, irq}, 8'h00);
    expect_reg("R11 pend kept on remask", A_PEND, 8'h01);
    wr(A_UNM, 8'h01);
    check("R11 irq again", {7'd0, irq}, 8'h01);
    wr(A_PEND, 8'h01);
    check("R11 clear drops irq", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = 3'd0; wdata = '0; gin = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle(6);
    t_mask();
    t_readback();
    t_rising();
    t_falling();
    t_both();
    t_level();
    t_w1c();
    t_collide();
    t_irq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule